// File: doc/BRIEF.md
# Serial EEPROM Write Guard

This block decides whether a serial EEPROM may change its memory array or its status byte. It keeps three kinds of protection state. The first is a volatile write-enable flag, which command strobes set and clear. The second is a lock-enable bit: when it is set, a board-level guard pin can freeze the status byte. The third is a two-bit block-protect code, which fences off the top quarter, the top half or all of the array. The command decoder in front of the block delivers one-cycle strobes for enable, disable and status write. It also delivers the status data byte, the select line, the guard pin level and the busy flag of the write engine. The block returns a grant for each array write request, a one-cycle grant when a status update takes effect, and the status byte that software reads.

A status write does not take effect when its strobe arrives. It is held pending while the select line stays low, and it commits on the cycle in which select is first sampled high. This matches the rule that deselect starts the internal write. If the guard pin drops while the lock is active and select is low, the pending update is discarded. Once the update has committed, the guard pin can no longer undo it.

The array size is a parameter, from 128 to 2048 bytes. The protected-range boundaries follow from it: size minus size/4 for the quarter range, and size minus size/2 for the half range.

Top module: `eeprom_write_guard`

## Requirements
- R1: After reset, the enable flag, the lock bit and the protect code are all 0. Both grants are low.
- R2: A set-enable strobe makes the enable flag 1 at the next edge, and a clear-enable strobe makes it 0. If both strobes come in the same cycle, clear wins. No other input changes the flag.
- R3: The status byte layout is: bit 7 is the lock bit, bits 3:2 are the protect code, bit 1 is the enable flag and bit 0 is the busy input. Bit 0 follows busy with no clock delay. Bits 6:4 read as 0.
- R4: The protect code is decoded as follows: 00 protects nothing; 01 protects addresses at or above size−size/4; 10 protects addresses at or above size−size/2; 11 protects every address.
- R5: `arr_grant` goes high in the cycle after a request exactly when the request was present, the enable flag was 1 and the address was not protected. In every other case it is low.
- R6: A status-write strobe sampled with select low and the enable flag at 1 becomes pending. It commits at the first edge where select is sampled high, loading bit 7 and bits 3:2 of its data. That edge raises `stat_grant` for exactly one cycle.
- R7: While the lock bit is 0, the guard pin level has no effect on status writes.
- R8: While the lock bit is 1, a low guard pin sampled with select low discards any pending status write, so nothing commits. After a commit, a low guard pin leaves the status byte unchanged.
- R9: A committed status write leaves the enable flag unchanged. It also ignores data bits 6:4, 1 and 0.
- R10: A status write is refused, with no change and no `stat_grant`, when the enable flag is 0, or when the lock bit is 1 and the guard pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_set_en | input | 1 | Set-enable command strobe |
| cmd_clr_en | input | 1 | Clear-enable command strobe |
| cmd_wr_stat | input | 1 | Status-write command strobe |
| stat_wdata | input | 8 | Data byte for the status write |
| sel_n | input | 1 | Device select, active low |
| guard_pin | input | 1 | Guard pin level; high permits status writes |
| busy | input | 1 | Write engine busy flag |
| wr_req | input | 1 | Array write request |
| wr_addr | input | AW | Array write byte address, AW = clog2(MEM_BYTES) |
| arr_grant | output | 1 | Array write permitted (one cycle after the request) |
| stat_grant | output | 1 | Status update committed this cycle |
| status_byte | output | 8 | Readable status byte |

## Verification
Each result of the block is due a fixed number of cycles after its stimulus. The enable flag, `arr_grant` and the status bits are due one edge after their stimulus. `stat_grant` and the status-byte update are due at the first edge after select rises, so they come two edges after the strobe when select rises in the next cycle. Only the ready bit follows its input at once.

The bench changes inputs just after a falling edge and reads outputs at the following falling edge. Every registered check therefore lands on the single rising edge between the two falling edges. The ready bit is read a nanosecond after busy changes.

The array grant is swept over every address of a 128-byte configuration under all four protect codes, with each expected value computed from the quarter and half boundaries.

// File: rtl/wguard_pkg.sv
package wguard_pkg;

    typedef enum logic [1:0] {
        FENCE_NONE = 2'b00,
        FENCE_QTR  = 2'b01,
        FENCE_HALF = 2'b10,
        FENCE_ALL  = 2'b11
    } fence_code_e;

    // Bit positions inside the readable status byte
    localparam int LOCK_POS = 7;
    localparam int FENCE_HI = 3;
    localparam int FENCE_LO = 2;
    localparam int EN_POS   = 1;
    localparam int RDY_POS  = 0;

    typedef struct packed {
        logic        en;         // write-enable flag
        logic        lock;       // lock-enable bit
        fence_code_e fence;      // block-protect code
        logic        pend_v;     // status write waiting for deselect
        logic        pend_lock;
        fence_code_e pend_fence;
        logic        sel_prev;   // select sampled last edge
        logic        sgrant;     // commit pulse
    } guard_state_t;

endpackage

// File: rtl/wguard_fence.sv
module wguard_fence
    import wguard_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic [AW-1:0] addr,
    input  fence_code_e   fence,
    output logic          hit
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] QTR_BASE  = CW'(MEM_BYTES - MEM_BYTES / 4);
    localparam logic [CW-1:0] HALF_BASE = CW'(MEM_BYTES - MEM_BYTES / 2);

    logic [CW-1:0] addr_w;
    assign addr_w = {1'b0, addr};

    always_comb begin
        unique case (fence)
            FENCE_NONE: hit = 1'b0;
            FENCE_QTR:  hit = (addr_w >= QTR_BASE);
            FENCE_HALF: hit = (addr_w >= HALF_BASE);
            default:    hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/wguard_regs.sv
module wguard_regs
    import wguard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_set_en,
    input  logic        cmd_clr_en,
    input  logic        cmd_wr_stat,
    input  logic        new_lock,
    input  fence_code_e new_fence,
    input  logic        sel_n,
    input  logic        guard_pin,
    output logic        en,
    output logic        lock,
    output fence_code_e fence,
    output logic        stat_grant
);
    guard_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sgrant   = 1'b0;
        st_d.sel_prev = sel_n;

        // enable flag: clear has priority over set
        if (cmd_set_en) st_d.en = 1'b1;
        if (cmd_clr_en) st_d.en = 1'b0;

        if (sel_n) begin
            // deselect starts the internal write
            if (!st_q.sel_prev && st_q.pend_v) begin
                st_d.lock   = st_q.pend_lock;
                st_d.fence  = st_q.pend_fence;
                st_d.sgrant = 1'b1;
            end
            st_d.pend_v = 1'b0;
        end else if (st_q.lock && !guard_pin) begin
            // guard pin low under lock: drop any pending update
            st_d.pend_v = 1'b0;
        end else if (cmd_wr_stat && st_q.en) begin
            st_d.pend_v     = 1'b1;
            st_d.pend_lock  = new_lock;
            st_d.pend_fence = new_fence;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, lock: 1'b0, fence: FENCE_NONE, pend_v: 1'b0,
                      pend_lock: 1'b0, pend_fence: FENCE_NONE, sel_prev: 1'b1,
                      sgrant: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign en         = st_q.en;
    assign lock       = st_q.lock;
    assign fence      = st_q.fence;
    assign stat_grant = st_q.sgrant;

    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_set_en && !cmd_clr_en) |=> en);
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr_en |=> !en);
    a_r9_en_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_set_en && !cmd_clr_en) |=> $stable(en));
    a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && lock && !guard_pin) |=> !st_q.pend_v);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stat_grant |=> !stat_grant);
    a_r6_loads_pending: assert property (@(posedge clk) disable iff (!rst_n)
        stat_grant |-> (lock == $past(st_q.pend_lock) && fence == $past(st_q.pend_fence)));
endmodule

// File: rtl/eeprom_write_guard.sv
module eeprom_write_guard
    import wguard_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_set_en,
    input  logic          cmd_clr_en,
    input  logic          cmd_wr_stat,
    input  logic [7:0]    stat_wdata,
    input  logic          sel_n,
    input  logic          guard_pin,
    input  logic          busy,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    output logic          arr_grant,
    output logic          stat_grant,
    output logic [7:0]    status_byte
);
    logic        en, lock, fenced;
    fence_code_e fence;
    logic        agrant_d, agrant_q;
    logic        unused_wdata_bits;

    assign unused_wdata_bits = ^{stat_wdata[6:4], stat_wdata[1:0]};

    wguard_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_set_en (cmd_set_en),
        .cmd_clr_en (cmd_clr_en),
        .cmd_wr_stat(cmd_wr_stat),
        .new_lock   (stat_wdata[LOCK_POS]),
        .new_fence  (fence_code_e'(stat_wdata[FENCE_HI:FENCE_LO])),
        .sel_n      (sel_n),
        .guard_pin  (guard_pin),
        .en         (en),
        .lock       (lock),
        .fence      (fence),
        .stat_grant (stat_grant)
    );

    wguard_fence #(.MEM_BYTES(MEM_BYTES)) u_fence (
        .addr (wr_addr),
        .fence(fence),
        .hit  (fenced)
    );

    always_comb begin
        agrant_d = wr_req && en && !fenced;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) agrant_q <= 1'b0;
        else        agrant_q <= agrant_d;
    end

    assign arr_grant = agrant_q;

    always_comb begin
        status_byte           = 8'h00;
        status_byte[LOCK_POS] = lock;
        status_byte[FENCE_HI:FENCE_LO] = fence;
        status_byte[EN_POS]   = en;
        status_byte[RDY_POS]  = busy;
    end

    a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant |-> $past(en && wr_req));
    a_r4_full_fence: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant |-> ($past(fence) != FENCE_ALL));
endmodule

// File: tb/tb_eeprom_write_guard.sv
module tb_eeprom_write_guard;
    localparam int MEM = 128;
    localparam int AW  = $clog2(MEM);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_set_en = 0, cmd_clr_en = 0, cmd_wr_stat = 0;
    logic [7:0] stat_wdata = 8'h00;
    logic sel_n = 1, guard_pin = 1, busy = 0, wr_req = 0;
    logic [AW-1:0] wr_addr = '0;
    logic arr_grant, stat_grant;
    logic [7:0] status_byte;

    int total = 0, bad = 0;
    logic m_en = 0, m_lock = 0;
    logic [1:0] m_fence = 2'b00;

    always #5 clk = ~clk;

    eeprom_write_guard #(.MEM_BYTES(MEM)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_set_en(cmd_set_en), .cmd_clr_en(cmd_clr_en),
        .cmd_wr_stat(cmd_wr_stat), .stat_wdata(stat_wdata), .sel_n(sel_n),
        .guard_pin(guard_pin), .busy(busy), .wr_req(wr_req), .wr_addr(wr_addr),
        .arr_grant(arr_grant), .stat_grant(stat_grant), .status_byte(status_byte)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_lock, 3'b000, m_fence, m_en, busy};
    endfunction

    // strobe in one cycle, deselect the next; commit is due at that second edge
    task automatic stat_write(input string req, input logic [7:0] d, input logic ok);
        sel_n = 0; cmd_wr_stat = 1; stat_wdata = d;
        tick();
        cmd_wr_stat = 0; sel_n = 1;
        tick();
        chk(req, stat_grant, ok);
        if (ok) begin m_lock = d[7]; m_fence = d[3:2]; end
        chk(req, status_byte, exp_status());
        tick();
        chk("R6 pulse", stat_grant, 0);
    endtask

    task automatic set_en(input logic s, input logic c);
        cmd_set_en = s; cmd_clr_en = c;
        tick();
        cmd_set_en = 0; cmd_clr_en = 0;
        if (c) m_en = 0; else if (s) m_en = 1;
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < MEM; a++) begin
            logic prot;
            case (m_fence)
                2'b00: prot = 0;
                2'b01: prot = (a >= MEM - MEM / 4);
                2'b10: prot = (a >= MEM - MEM / 2);
                default: prot = 1;
            endcase
            wr_req = 1; wr_addr = a[AW-1:0];
            tick();
            chk(req, arr_grant, m_en && !prot);
        end
        wr_req = 0;
        tick();
        chk("R5 idle", arr_grant, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 status", status_byte, 8'h00);
        chk("R1 arr_grant", arr_grant, 0);
        chk("R1 stat_grant", stat_grant, 0);
        // R3 ready bit follows busy without delay
        busy = 1; #1;
        chk("R3 ready", status_byte, exp_status());
        tick(); busy = 0; #1;
        chk("R3 ready low", status_byte, exp_status());
        // R10 refused while enable flag is 0; R5 no grants
        stat_write("R10 no enable", 8'h8C, 0);
        sweep("R5 disabled");
        // R2 set, clear, collision
        set_en(1, 0); chk("R2 set", status_byte, exp_status());
        set_en(0, 1); chk("R2 clear", status_byte, exp_status());
        set_en(1, 1); chk("R2 clear wins", status_byte, exp_status());
        set_en(1, 0);
        tick(); chk("R2 held", status_byte[1], 1);
        // R9 ignored bits, enable kept
        stat_write("R9 masked write", 8'h77, 1);
        chk("R9 enable kept", status_byte[1], 1);
        // R4/R5 sweep every fence code
        for (int f = 0; f < 4; f++) begin
            stat_write("R4 fence load", {4'b0000, f[1:0], 2'b00}, 1);
            sweep("R4 R5 sweep");
        end
        // R7 pin ignored with lock 0
        guard_pin = 0;
        stat_write("R7 pin ignored", 8'h08, 1);
        guard_pin = 1;
        stat_write("R6 set lock", 8'h80, 1);
        // R10 locked and pin low
        guard_pin = 0;
        stat_write("R10 locked", 8'h0C, 0);
        guard_pin = 1;
        // R8 cancel pending update
        sel_n = 0; cmd_wr_stat = 1; stat_wdata = 8'h84;
        tick();
        cmd_wr_stat = 0; guard_pin = 0;
        tick();
        guard_pin = 1; sel_n = 1;
        tick();
        chk("R8 cancel grant", stat_grant, 0);
        chk("R8 cancel status", status_byte, exp_status());
        // R8 after commit pin has no effect
        stat_write("R8 commit", 8'h88, 1);
        guard_pin = 0;
        tick(); tick();
        chk("R8 after commit", status_byte, exp_status());
        guard_pin = 1;
        // R10 refused after clear
        set_en(0, 1);
        stat_write("R10 after clear", 8'h00, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule